// File: doc/BRIEF.md
# Shared-Bus Quad SPI Master

This block is a quad SPI master for a bus that other masters also use. It drives the serial clock and the four data lines only while it owns the bus. At every other time those lines are left at high impedance. Chip select is wired open-drain with an external pull-up. The block can only pull that line low or let it go, and it reads the line back through its own input.

A transfer begins with a one-cycle `req` pulse. Before the block claims the bus, it must see chip select high on two system-clock edges in a row. If another master is holding the line low, the request is held and is retried automatically. During the claim, the block turns on its clock and data drivers first and pulls chip select low only after that. It then checks that the line really went low. If the bus is taken during this hand-over, or the line does not go low, the transfer is abandoned and flagged as lost.

A frame is an 8-bit instruction followed by 1 to 16 data bytes. Both are sent four bits per serial clock, in SPI mode 0. Control and data bytes are presented on wide parallel ports. The block is restarted for each frame without any reconfiguration.

Top module: `mmqspi_ctrl`

## Requirements
- R1: Whenever `busy` is low, `sck_oe`, `dio_oe` and `cs_pull` are all low. This holds from reset onwards and after every completed or abandoned frame.
- R2: `cs_pull` = 1 means the pad is driven low, and `cs_pull` = 0 means the pad is released. `cs_pull` rises only while `sck_oe` is high, `dio_oe` is 4'hF and `sck_o` is low.
- R3: A request is accepted only when `cs_i` has been sampled high on two consecutive clock edges. While `cs_i` reads low, `deferred` and `busy` stay high and no line is driven. The request is retried without a new `req` pulse.
- R4: In the cycle after the drivers turn on, the block samples `cs_i` once more. If it reads low (another master seized the bus), the block never pulls chip select. It ends the frame with `done` and `lost` high in the same cycle.
- R5: One cycle after `cs_pull` rises, `cs_i` is read back. If it is still high, the block releases the bus and ends the frame with `done` and `lost` high.
- R6: A frame carries `cmd` and then `len`+1 bytes, with byte i taken from `wdata[8i+7:8i]`. Each byte is sent upper nibble first, with bit 3 of a nibble on `dio[3]`. Exactly 2 + 2(`len`+1) rising serial-clock edges occur.
- R7: `sck_o` idles low. Data changes only with the falling edge and is sampled at the rising edge. Each half period lasts `half_div` system clocks, and a value of 0 is treated as 1.
- R8: When `wr` = 0, `dio_oe` drops to 0 at the falling edge that follows the instruction. The nibbles sampled afterwards fill `rdata`, with byte i in `rdata[8i+7:8i]`.
- R9: One half period after the last rising edge, `sck_o` falls and `cs_pull` is released together. On the next cycle both output enables drop, `done` pulses and `busy` falls.
- R10: A `req` pulse while `busy` is high is ignored.
- R11: A `req` raised in the cycle that shows `done` is accepted at once. With the bus free, `sck_oe` rises on the third clock edge after that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start pulse, sampled while idle |
| wr | input | 1 | 1 = write data phase, 0 = read data phase |
| cmd | input | 8 | Instruction byte |
| len | input | LEN_W | Number of data bytes minus one |
| wdata | input | 8*MAX_BYTES | Write bytes, byte 0 in the low bits |
| half_div | input | DIV_W | Serial clock half period in system clocks |
| busy | output | 1 | Request accepted and not yet finished |
| done | output | 1 | One-cycle end-of-frame pulse |
| lost | output | 1 | Set with `done` when the bus could not be claimed |
| deferred | output | 1 | Waiting because another master holds the bus |
| rdata | output | 8*MAX_BYTES | Read bytes, byte 0 in the low bits |
| sck_o | output | 1 | Serial clock output value |
| sck_oe | output | 1 | Serial clock output enable |
| cs_pull | output | 1 | Pull chip select low when 1 |
| cs_i | input | 1 | Chip select pad level |
| dio_o | output | 4 | Data output values |
| dio_oe | output | 4 | Data output enables |
| dio_i | input | 4 | Data pad levels |

## Verification
The bench holds chip select low from a second master, and also lets it go for a single cycle. A design that claims on one high sample, or that needs a fresh request, would drive the bus at the wrong time or hang. It seizes the line in the cycle after the drivers come up, and it pins the pad high, to check that the frame ends as lost instead of clocking data into a bus it does not own. Frames run at the shortest and longest lengths, in both directions, and with a zero divider, so that a nibble-order slip, a turnaround on the wrong edge or a wrong half period shows up as a data mismatch or a bad pulse width. It also checks the release order at the end of a frame and the restart gap, where driving chip select after the enables drop, or adding extra idle cycles, is exposed.

// File: rtl/mmqspi_ctrl.sv
module mmqspi_ctrl #(
  parameter int MAX_BYTES = 16,
  parameter int DIV_W     = 8,
  localparam int LEN_W    = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
  localparam int NIB_W    = $clog2(2 * MAX_BYTES + 4)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req,
  input  logic                   wr,
  input  logic [7:0]             cmd,
  input  logic [LEN_W-1:0]       len,
  input  logic [8*MAX_BYTES-1:0] wdata,
  input  logic [DIV_W-1:0]       half_div,
  output logic                   busy,
  output logic                   done,
  output logic                   lost,
  output logic                   deferred,
  output logic [8*MAX_BYTES-1:0] rdata,
  output logic                   sck_o,
  output logic                   sck_oe,
  output logic                   cs_pull,
  input  logic                   cs_i,
  output logic [3:0]             dio_o,
  output logic [3:0]             dio_oe,
  input  logic [3:0]             dio_i
);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_SETUP, S_CLAIM, S_LO, S_HI, S_END} st_t;

  st_t                   st;
  logic [DIV_W-1:0]      hcnt;
  logic [NIB_W-1:0]      nib, last;
  logic                  free1, abort, wr_q;
  logic [7:0]            cmd_q;
  logic [8*MAX_BYTES-1:0] wd_q, rd_q;
  int unsigned           bofs;

  wire [DIV_W-1:0] hd       = (half_div == '0) ? DIV_W'(1) : half_div;
  wire             half_end = (hcnt == hd - DIV_W'(1));
  wire             rd_phase = !wr_q && (nib >= NIB_W'(2));

  assign busy  = (st != S_IDLE);
  assign rdata = rd_q;

  always_comb begin
    bofs = 0;
    if (nib >= NIB_W'(2))
      bofs = ((int'(nib) - 2) / 2) * 8 + (nib[0] ? 0 : 4);
    if (nib == NIB_W'(0))      dio_o = cmd_q[7:4];
    else if (nib == NIB_W'(1)) dio_o = cmd_q[3:0];
    else                       dio_o = wd_q[bofs +: 4];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; hcnt <= '0; nib <= '0; last <= '0;
      free1 <= 1'b0; abort <= 1'b0; wr_q <= 1'b0; cmd_q <= '0;
      wd_q <= '0; rd_q <= '0; done <= 1'b0; lost <= 1'b0; deferred <= 1'b0;
      sck_o <= 1'b0; sck_oe <= 1'b0; cs_pull <= 1'b0; dio_oe <= 4'h0;
    end else begin
      done <= 1'b0;
      lost <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          wr_q  <= wr;
          cmd_q <= cmd;
          wd_q  <= wdata;
          last  <= NIB_W'({len, 1'b1}) + NIB_W'(2);
          free1 <= 1'b0;
          abort <= 1'b0;
          st    <= S_WAIT;
        end
        S_WAIT: if (cs_i) begin
          free1 <= 1'b1;
          if (free1) begin
            sck_oe   <= 1'b1;
            sck_o    <= 1'b0;
            dio_oe   <= 4'hF;
            nib      <= '0;
            deferred <= 1'b0;
            st       <= S_SETUP;
          end
        end else begin
          free1    <= 1'b0;
          deferred <= 1'b1;
        end
        S_SETUP: if (!cs_i) begin
          abort <= 1'b1;
          st    <= S_END;
        end else begin
          cs_pull <= 1'b1;
          st      <= S_CLAIM;
        end
        S_CLAIM: if (cs_i) begin
          abort   <= 1'b1;
          cs_pull <= 1'b0;
          st      <= S_END;
        end else begin
          hcnt <= '0;
          st   <= S_LO;
        end
        S_LO: if (half_end) begin
          hcnt  <= '0;
          sck_o <= 1'b1;
          if (rd_phase) rd_q[bofs +: 4] <= dio_i;
          st    <= S_HI;
        end else hcnt <= hcnt + DIV_W'(1);
        S_HI: if (half_end) begin
          hcnt  <= '0;
          sck_o <= 1'b0;
          if (nib == last) begin
            cs_pull <= 1'b0;
            st      <= S_END;
          end else begin
            nib <= nib + NIB_W'(1);
            if (!wr_q && nib == NIB_W'(1)) dio_oe <= 4'h0;
            st  <= S_LO;
          end
        end else hcnt <= hcnt + DIV_W'(1);
        S_END: begin
          sck_oe <= 1'b0;
          dio_oe <= 4'h0;
          done   <= 1'b1;
          lost   <= abort;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sck_oe && dio_oe == 4'h0 && !cs_pull));

  // R2
  cs_after_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_pull |-> sck_oe);

  // R3
  guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_pull) |-> ($past(cs_i) && $past(cs_i, 2)));

  // R3
  defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deferred |-> (busy && !cs_pull && !sck_oe));

  // R4
  lost_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost |-> done);

  // R7
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_pull |-> !sck_o);

  // R9
  release_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_pull) |-> sck_oe);

  // R9
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

endmodule

// File: tb/sim_mmqspi_ctrl.sv
`timescale 1ns/1ps
module sim_mmqspi_ctrl;
  localparam int MB = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req = 1'b0, wr = 1'b0;
  logic [7:0] cmd = 8'h00;
  logic [3:0] len = 4'h0;
  logic [8*MB-1:0] wdata = '0;
  logic [7:0] half_div = 8'd1;
  logic busy, done, lost, deferred;
  logic [8*MB-1:0] rdata;
  logic sck_o, sck_oe, cs_pull, cs_i;
  logic [3:0] dio_o, dio_oe, dio_i;

  logic other = 1'b0, stuck = 1'b0, rd_frame = 1'b0;
  logic [7:0] smem [MB];
  logic [3:0] sdrv = 4'h0;
  logic [4:0] exp_q [$];
  int sn = 0, nchk = 0, nfail = 0, exp_half = 1, hi_len = 0;
  logic prev_pull = 1'b0, pend_rel = 1'b0;

  assign cs_i = stuck ? 1'b1 : !(cs_pull || other);
  wire slv_oe = !cs_i && rd_frame && (sn >= 2);
  assign dio_i = (dio_o & dio_oe) | (~dio_oe & (slv_oe ? sdrv : 4'h0));

  mmqspi_ctrl #(.MAX_BYTES(MB), .DIV_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .cmd(cmd), .len(len),
    .wdata(wdata), .half_div(half_div), .busy(busy), .done(done), .lost(lost),
    .deferred(deferred), .rdata(rdata), .sck_o(sck_o), .sck_oe(sck_oe),
    .cs_pull(cs_pull), .cs_i(cs_i), .dio_o(dio_o), .dio_oe(dio_oe), .dio_i(dio_i));

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] snib(input int k);
    int b;
    b = (k - 2) / 2;
    if (b >= MB) return 4'h0;
    return (k % 2 == 0) ? smem[b][7:4] : smem[b][3:0];
  endfunction

  // slave and scoreboard monitor
  always @(negedge cs_i) sn = 0;
  always @(negedge sck_o) if (sn >= 2) sdrv = snib(sn);
  always @(posedge sck_o) if (!cs_i) begin
    logic [4:0] e;
    if (exp_q.size() == 0) chk(1'b0, "R6 extra serial clock edge", 128'(sn), 0);
    else begin
      e = exp_q.pop_front();
      chk(dio_i == e[3:0], "R6/R8 bus nibble", 128'(dio_i), 128'(e[3:0]));
      chk(dio_oe == (e[4] ? 4'hF : 4'h0), "R8 data direction", 128'(dio_oe), e[4] ? 128'hF : 0);
    end
    sn = sn + 1;
  end

  // release order, claim order and half period monitor
  always @(negedge clk) if (rst_n) begin
    if (pend_rel) begin
      chk(!sck_oe && dio_oe == 4'h0 && done, "R9 enables off with done one cycle after release",
          128'({sck_oe, dio_oe, done}), 128'(5'b00001));
      pend_rel = 1'b0;
    end
    if (prev_pull && !cs_pull) begin
      chk(sck_oe && !sck_o, "R9 cs released while clock driven low", 128'({sck_oe, sck_o}), 128'(2'b10));
      pend_rel = 1'b1;
    end
    if (!prev_pull && cs_pull)
      chk(sck_oe && dio_oe == 4'hF && !sck_o, "R2 drivers on before cs pull",
          128'({sck_oe, dio_oe, sck_o}), 128'(6'b111110));
    prev_pull = cs_pull;
    if (sck_o) hi_len++;
    else if (hi_len > 0) begin
      chk(hi_len == exp_half, "R7 clock high half period", 128'(hi_len), 128'(exp_half));
      hi_len = 0;
    end
  end

  task automatic prep(input bit w, input logic [7:0] c, input int n, input int hdv);
    wr = w; cmd = c; len = 4'(n - 1); half_div = 8'(hdv);
    exp_half = (hdv == 0) ? 1 : hdv;
    rd_frame = !w;
    for (int i = 0; i < MB; i++) begin
      wdata[8*i +: 8] = 8'(i * 29 + int'(c));
      smem[i] = 8'(i * 53 + int'(c) + 7);
    end
    exp_q.push_back({1'b1, c[7:4]});
    exp_q.push_back({1'b1, c[3:0]});
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = w ? wdata[8*i +: 8] : smem[i];
      exp_q.push_back({w, b[7:4]});
      exp_q.push_back({w, b[3:0]});
    end
  endtask

  task automatic fire();
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic finish(input bit w, input int n);
    while (!done) @(negedge clk);
    chk(!lost, "R4/R5 no loss on a free bus", 128'(lost), 0);
    chk(!busy && !sck_oe && dio_oe == 4'h0 && !cs_pull, "R1 lines released after frame",
        128'({busy, sck_oe, dio_oe, cs_pull}), 0);
    chk(exp_q.size() == 0, "R6 all nibbles clocked", 128'(exp_q.size()), 0);
    exp_q.delete();
    if (!w)
      for (int i = 0; i < n; i++)
        chk(rdata[8*i +: 8] == smem[i], "R8 read byte", 128'(rdata[8*i +: 8]), 128'(smem[i]));
  endtask

  task automatic xfer(input bit w, input logic [7:0] c, input int n, input int hdv, input bit gap, input bit poke);
    prep(w, c, n, hdv);
    fire();
    if (gap) begin
      chk(!sck_oe, "R3 no drive after first sample", 128'(sck_oe), 0);
      @(negedge clk);
      chk(!sck_oe, "R3 no drive after second sample", 128'(sck_oe), 0);
      @(negedge clk);
      chk(sck_oe, "R11 drivers on at third edge", 128'(sck_oe), 1);
    end
    if (poke) begin
      repeat (6) @(negedge clk);
      cmd = 8'hFF;
      fire();
    end
    finish(w, n);
    if (poke) begin
      repeat (8) @(negedge clk);
      chk(!busy && !sck_oe, "R10 request during busy ignored", 128'({busy, sck_oe}), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !deferred && !sck_oe && dio_oe == 4'h0 && !cs_pull, "R1 reset state",
        128'({busy, done, deferred, sck_oe, dio_oe, cs_pull}), 0);

    xfer(1'b1, 8'hA5, 1, 1, 1'b1, 1'b0);
    xfer(1'b0, 8'h12, 1, 1, 1'b1, 1'b0);   // R11 back-to-back
    xfer(1'b1, 8'h3C, 3, 3, 1'b0, 1'b0);
    xfer(1'b0, 8'h9E, 2, 2, 1'b0, 1'b0);
    xfer(1'b0, 8'h71, 16, 1, 1'b0, 1'b0);
    xfer(1'b1, 8'h5A, 16, 0, 1'b0, 1'b0);  // R7 zero divider

    // R3 deferral and guard
    other = 1'b1;
    repeat (2) @(negedge clk);
    prep(1'b1, 8'h66, 2, 1);
    fire();
    repeat (8) @(negedge clk);
    chk(deferred && busy && !sck_oe && !cs_pull, "R3 deferred while bus held",
        128'({deferred, busy, sck_oe, cs_pull}), 128'(4'b1100));
    other = 1'b0;
    @(negedge clk);
    other = 1'b1;
    repeat (6) @(negedge clk);
    chk(!sck_oe && deferred, "R3 single high sample not enough", 128'({sck_oe, deferred}), 128'(2'b01));
    other = 1'b0;
    finish(1'b1, 2);
    chk(!deferred, "R3 deferred cleared after retry", 128'(deferred), 0);

    // R4 seizure during drive setup
    repeat (3) @(negedge clk);
    wr = 1'b1;
    fire();
    while (!sck_oe) @(negedge clk);
    other = 1'b1;
    while (!done) @(negedge clk);
    chk(lost, "R4 seizure reported as lost", 128'(lost), 1);
    chk(!busy && !sck_oe && dio_oe == 4'h0 && !cs_pull, "R4 released after loss",
        128'({busy, sck_oe, dio_oe, cs_pull}), 0);
    other = 1'b0;

    // R5 chip select fails to go low
    repeat (3) @(negedge clk);
    stuck = 1'b1;
    fire();
    while (!done) @(negedge clk);
    chk(lost, "R5 failed readback reported as lost", 128'(lost), 1);
    stuck = 1'b0;
    repeat (3) @(negedge clk);

    xfer(1'b1, 8'hC3, 4, 2, 1'b0, 1'b1);   // R10

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule